// File: doc/BRIEF.md
# Floating-Point Min/Max Special-Case Resolver

This block takes two 128-bit vectors of IEEE floating-point values and produces, for each lane, the minimum or the maximum of the two operands. The lanes are either four binary32 values or two binary64 values. Ordinary numbers give the same answer in every mode. What the mode decides is the answer for NaN operands and for two zeros. Different programming languages expect different results there, so the caller picks the convention that matches the code being run.

A 4-bit mode input selects the convention. Its top bit makes the operation work on magnitudes. A single-lane input computes only the lowest lane and zeroes the rest. The result and a sticky-free invalid indication are registered and appear one clock after the inputs are applied. The first operand is `a_i`, the second is `b_i`.

Top module: `fmm_resolver`

## Requirements
- R1: While `rst_ni` is low, `res_o` and `invalid_o` are zero. Otherwise both outputs show the result for the inputs present at the previous rising edge of `clk_i`.
- R2: `dbl_i`=0 selects four binary32 lanes, with lane k at bits [32k+31:32k]. `dbl_i`=1 selects two binary64 lanes, with lane k at bits [64k+63:64k]. `max_i`=1 gives the maximum and 0 the minimum. For non-NaN operands that are not both zero, the numerically smaller or larger operand is returned unchanged in every mode, with -0 ordered below +0.
- R3: `mode_i[2:0]` selects the convention: 0 IEEE, 1 Java, 2 C-macro, 3 C++, 4 Fortran. Codes 5 to 7 behave as IEEE. `mode_i[3]`=1 selects magnitude operation.
- R4: Java mode with a NaN present returns one of four things, checked in this order. If the first operand is signaling, it returns the first operand quieted. Else, if the second is signaling, it returns the second quieted. Else, if the first is a NaN, it returns the first. Otherwise it returns the second.
- R5: Fortran mode with a NaN present returns the first operand when the second is NaN, and the second operand otherwise.
- R6: With a NaN present, C-macro mode returns the second operand and C++ mode returns the first. Both raise invalid, even for quiet NaNs.
- R7: When both operands are zero (either sign), the result depends on the mode. C-macro returns the second operand and C++ returns the first. Java and Fortran min return the first operand if it is negative, else the second. Java and Fortran max return the second operand if the first is negative, else the first.
- R8: In IEEE mode, a quiet NaN paired with a number yields the number. A signaling NaN yields that NaN quieted. Two NaNs yield the first one quieted. Any signaling NaN raises invalid.
- R9: With magnitude operation, the non-IEEE modes clear both sign bits before resolving, so results carry sign 0. IEEE mode returns the original operand with the smaller (min) or larger (max) magnitude, and falls back to the R2 ordering when the magnitudes are equal.
- R10: Quieting a NaN sets the most significant fraction bit and keeps every other bit.
- R11: Invalid is raised by any signaling NaN in a computed lane in Java and Fortran modes. `invalid_o` is the OR over all computed lanes.
- R12: With `single_i`=1, only lane 0 is computed. All other result bits are zero, and the other lanes cannot raise invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 128 | First operand vector |
| b_i | input | 128 | Second operand vector |
| dbl_i | input | 1 | 1: binary64 lanes, 0: binary32 lanes |
| max_i | input | 1 | 1: maximum, 0: minimum |
| mode_i | input | 4 | Convention in [2:0], magnitude select in [3] |
| single_i | input | 1 | Compute lane 0 only |
| res_o | output | 128 | Registered result vector |
| invalid_o | output | 1 | Registered invalid indication |

## Verification
The only state is the output register, so a fault there appears at the ports one cycle after the inputs that should have produced it. It shows up as a wrong lane value, a non-zero upper lane in single-lane use, or an invalid flag with no NaN behind it. A wrong lane-select or mode-decode path corrupts whole lanes, and a directed pattern that gives every lane a different expected value exposes it. The NaN and zero tables are checked lane by lane, with each lane carrying a different operand pairing, so a swapped or mis-prioritised branch changes exactly one visible lane.

// File: rtl/fmm_pkg.sv
package fmm_pkg;
  typedef enum logic [2:0] {
    MM_IEEE = 3'd0,
    MM_JAVA = 3'd1,
    MM_CMAC = 3'd2,
    MM_CPP  = 3'd3,
    MM_FORT = 3'd4
  } mm_kind_e;

  // reserved codes fall back to IEEE
  function automatic mm_kind_e to_kind(input logic [2:0] code);
    case (code)
      3'd1:    return MM_JAVA;
      3'd2:    return MM_CMAC;
      3'd3:    return MM_CPP;
      3'd4:    return MM_FORT;
      default: return MM_IEEE;
    endcase
  endfunction
endpackage

// File: rtl/fmm_class.sv
module fmm_class #(
  parameter int W = 32,
  parameter int E = 8
) (
  input  logic [W-1:0] x_i,
  output logic         nan_o,
  output logic         snan_o,
  output logic         zero_o
);
  localparam int F = W - 1 - E;

  logic [E-1:0] expo;
  logic [F-1:0] frac;

  assign expo   = x_i[W-2 -: E];
  assign frac   = x_i[F-1:0];
  assign nan_o  = (&expo) && (|frac);
  assign snan_o = nan_o && !frac[F-1];
  assign zero_o = (expo == '0) && (frac == '0);
endmodule

// File: rtl/fmm_lane.sv
module fmm_lane
  import fmm_pkg::*;
#(
  parameter int W = 32,
  parameter int E = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         max_i,
  input  mm_kind_e     kind_i,
  input  logic         abs_i,
  output logic [W-1:0] res_o,
  output logic         invalid_o,
  output logic         nan_any_o
);
  localparam int F = W - 1 - E;
  localparam logic [W-1:0] QBIT = W'(1) << (F - 1);

  logic         clr_sgn;
  logic [W-1:0] opa, opb, qa, qb, ord, ieee_pick;
  logic         na, nb, sa, sb, za, zb;
  logic         a_lt_b, mag_lt, mag_eq;

  assign clr_sgn = abs_i && (kind_i != MM_IEEE);
  assign opa = clr_sgn ? {1'b0, a_i[W-2:0]} : a_i;
  assign opb = clr_sgn ? {1'b0, b_i[W-2:0]} : b_i;
  assign qa  = opa | QBIT;
  assign qb  = opb | QBIT;

  fmm_class #(.W(W), .E(E)) u_cls_a (.x_i(opa), .nan_o(na), .snan_o(sa), .zero_o(za));
  fmm_class #(.W(W), .E(E)) u_cls_b (.x_i(opb), .nan_o(nb), .snan_o(sb), .zero_o(zb));

  // total order on non-NaN values, -0 below +0
  always_comb begin
    if (opa[W-1] != opb[W-1]) a_lt_b = opa[W-1];
    else if (opa[W-1])        a_lt_b = opa[W-2:0] > opb[W-2:0];
    else                      a_lt_b = opa[W-2:0] < opb[W-2:0];
  end

  assign ord    = max_i ? (a_lt_b ? opb : opa) : (a_lt_b ? opa : opb);
  assign mag_lt = opa[W-2:0] < opb[W-2:0];
  assign mag_eq = opa[W-2:0] == opb[W-2:0];
  assign ieee_pick = (abs_i && !mag_eq) ?
                     (max_i ? (mag_lt ? opb : opa) : (mag_lt ? opa : opb)) : ord;

  always_comb begin
    invalid_o = 1'b0;
    res_o     = ord;
    case (kind_i)
      MM_JAVA: begin
        if (na || nb) begin
          invalid_o = sa || sb;
          res_o = sa ? qa : (sb ? qb : (na ? opa : opb));
        end else if (za && zb) begin
          res_o = max_i ? (opa[W-1] ? opb : opa) : (opa[W-1] ? opa : opb);
        end
      end
      MM_FORT: begin
        if (na || nb) begin
          invalid_o = sa || sb;
          res_o = nb ? opa : opb;
        end else if (za && zb) begin
          res_o = max_i ? (opa[W-1] ? opb : opa) : (opa[W-1] ? opa : opb);
        end
      end
      MM_CMAC: begin
        if (na || nb) begin
          invalid_o = 1'b1;
          res_o = opb;
        end else if (za && zb) begin
          res_o = opb;
        end
      end
      MM_CPP: begin
        if (na || nb) begin
          invalid_o = 1'b1;
          res_o = opa;
        end else if (za && zb) begin
          res_o = opa;
        end
      end
      default: begin
        invalid_o = sa || sb;
        if (na && nb)  res_o = qa;
        else if (na)   res_o = sa ? qa : opb;
        else if (nb)   res_o = sb ? qb : opa;
        else           res_o = ieee_pick;
      end
    endcase
  end

  assign nan_any_o = na || nb;
endmodule

// File: rtl/fmm_resolver.sv
module fmm_resolver
  import fmm_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic             dbl_i,
  input  logic             max_i,
  input  logic [3:0]       mode_i,
  input  logic             single_i,
  output logic [VEC_W-1:0] res_o,
  output logic             invalid_o
);
  localparam int N32 = VEC_W / 32;
  localparam int N64 = VEC_W / 64;

  mm_kind_e kind;
  assign kind = to_kind(mode_i[2:0]);

  logic [31:0]    r32 [N32];
  logic [63:0]    r64 [N64];
  logic [N32-1:0] inv32, nan32, act32;
  logic [N64-1:0] inv64, nan64, act64;

  for (genvar i = 0; i < N32; i++) begin : g_s
    fmm_lane #(.W(32), .E(8)) u_lane (
      .a_i(a_i[32*i +: 32]), .b_i(b_i[32*i +: 32]), .max_i(max_i),
      .kind_i(kind), .abs_i(mode_i[3]),
      .res_o(r32[i]), .invalid_o(inv32[i]), .nan_any_o(nan32[i]));
    assign act32[i] = !single_i || (i == 0);
  end

  for (genvar i = 0; i < N64; i++) begin : g_d
    fmm_lane #(.W(64), .E(11)) u_lane (
      .a_i(a_i[64*i +: 64]), .b_i(b_i[64*i +: 64]), .max_i(max_i),
      .kind_i(kind), .abs_i(mode_i[3]),
      .res_o(r64[i]), .invalid_o(inv64[i]), .nan_any_o(nan64[i]));
    assign act64[i] = !single_i || (i == 0);
  end

  logic [VEC_W-1:0] nxt_res;
  logic             nxt_inv, nan_seen;

  always_comb begin
    nxt_res = '0;
    if (dbl_i) begin
      for (int i = 0; i < N64; i++)
        if (act64[i]) nxt_res[64*i +: 64] = r64[i];
    end else begin
      for (int i = 0; i < N32; i++)
        if (act32[i]) nxt_res[32*i +: 32] = r32[i];
    end
  end

  assign nxt_inv  = dbl_i ? |(inv64 & act64) : |(inv32 & act32);
  assign nan_seen = dbl_i ? |(nan64 & act64) : |(nan32 & act32);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o     <= '0;
      invalid_o <= 1'b0;
    end else begin
      res_o     <= nxt_res;
      invalid_o <= nxt_inv;
    end
  end

  // R12
  single_dbl_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (single_i && dbl_i) |=> (res_o[VEC_W-1:64] == '0));

  // R12
  single_sgl_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (single_i && !dbl_i) |=> (res_o[VEC_W-1:32] == '0));

  // R11
  invalid_has_nan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> $past(nan_seen));

  // R6
  cpp_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbl_i && mode_i == 4'd3 && nan64[0]) |-> (r64[0] == a_i[63:0]));

  // R4
  java_nan_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbl_i && mode_i == 4'd1 && nan64[0]) |-> ((&r64[0][62:52]) && (|r64[0][51:0])));
endmodule

// File: tb/sim_fmm_resolver.sv
module sim_fmm_resolver;
  localparam int CLK_P = 10;

  localparam logic [31:0] S1 = 32'h3F800000, S2 = 32'h40000000, SM1 = 32'hBF800000;
  localparam logic [31:0] SM3 = 32'hC0400000, SP0 = 32'h00000000, SN0 = 32'h80000000;
  localparam logic [31:0] SQN = 32'h7FC00000, SSN = 32'h7F800001, SSNQ = 32'h7FC00001;
  localparam logic [63:0] D1 = 64'h3FF0000000000000, D2 = 64'h4000000000000000;
  localparam logic [63:0] DQN = 64'h7FF8000000000000, DSN = 64'h7FF0000000000005;
  localparam logic [63:0] DSNQ = 64'h7FF8000000000005;

  logic         clk_i = 1'b0, rst_ni = 1'b0;
  logic [127:0] a_i = '0, b_i = '0, res_o;
  logic         dbl_i = 1'b0, max_i = 1'b0, single_i = 1'b0, invalid_o;
  logic [3:0]   mode_i = '0;
  int           n_run = 0, n_fail = 0;
  bit           done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  fmm_resolver u0 (.clk_i, .rst_ni, .a_i, .b_i, .dbl_i, .max_i, .mode_i,
                   .single_i, .res_o, .invalid_o);

  task automatic chk(input string tag, input logic [127:0] er, input logic ei);
    n_run++;
    if (res_o !== er || invalid_o !== ei) begin
      n_fail++;
      $display("FAIL %s res=%h inv=%b expected res=%h inv=%b", tag, res_o, invalid_o, er, ei);
    end
  endtask

  task automatic run(input string tag, input logic [127:0] a, input logic [127:0] b,
                     input logic dbl, input logic mx, input logic [3:0] md,
                     input logic sg, input logic [127:0] er, input logic ei);
    @(negedge clk_i);
    a_i = a; b_i = b; dbl_i = dbl; max_i = mx; mode_i = md; single_i = sg;
    @(negedge clk_i);
    chk(tag, er, ei);
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk("R1 reset", '0, 1'b0);
  endtask

  task automatic t_ordinary;
    run("R2 ieee min32", {S2, SM1, SP0, S1}, {S1, SM3, SN0, S1}, 0, 0, 4'd0, 0,
        {S1, SM3, SN0, S1}, 0);
    run("R2 ieee max32", {S2, SM1, SP0, S1}, {S1, SM3, SN0, S1}, 0, 1, 4'd0, 0,
        {S2, SM1, SP0, S1}, 0);
    run("R2 java max64", {D1, D2}, {D2, D1}, 1, 1, 4'd1, 0, {D2, D2}, 0);
  endtask

  task automatic t_java;
    run("R4 R10 java snan", {DSN, D1}, {D1, DQN}, 1, 0, 4'd1, 0, {DSNQ, DQN}, 1);
    run("R4 java order", {DQN, DQN}, {DSN, D2}, 1, 0, 4'd1, 0, {DSNQ, DQN}, 1);
  endtask

  task automatic t_fortran;
    run("R5 R11 fortran", {SSN, S1, S2, SQN}, {S1, SQN, S1, SM1}, 0, 1, 4'd4, 0,
        {S1, S1, S2, SM1}, 1);
  endtask

  task automatic t_cstyle;
    run("R6 cmacro", {SQN, S1, S1, S2}, {S2, SQN, S2, S1}, 0, 0, 4'd2, 0,
        {S2, SQN, S1, S1}, 1);
    run("R6 cpp", {SQN, S1, S1, S2}, {S2, SQN, S2, S1}, 0, 0, 4'd3, 0,
        {SQN, S1, S1, S1}, 1);
    run("R6 cpp no nan", {S2, S1, S1, S2}, {S1, S2, S2, S1}, 0, 0, 4'd3, 0,
        {S1, S1, S1, S1}, 0);
  endtask

  task automatic t_zeros;
    logic [127:0] za = {SN0, SP0, SN0, SP0}, zb = {SP0, SN0, SN0, SP0};
    run("R7 java min", za, zb, 0, 0, 4'd1, 0, {SN0, SN0, SN0, SP0}, 0);
    run("R7 java max", za, zb, 0, 1, 4'd1, 0, {SP0, SP0, SN0, SP0}, 0);
    run("R7 fortran min", za, zb, 0, 0, 4'd4, 0, {SN0, SN0, SN0, SP0}, 0);
    run("R7 cmacro max", za, zb, 0, 1, 4'd2, 0, zb, 0);
    run("R7 cpp min", za, zb, 0, 0, 4'd3, 0, za, 0);
  endtask

  task automatic t_ieee_nan;
    run("R8 ieee64 max", {DQN, D1}, {D1, DSN}, 1, 1, 4'd0, 0, {D1, DSNQ}, 1);
    run("R8 R3 reserved code", {SQN, S2, SSN, S1}, {SQN, SQN, S2, SQN}, 0, 0, 4'd5, 0,
        {SQN, S2, SSNQ, S1}, 1);
  endtask

  task automatic t_abs;
    logic [127:0] xa = {SM3, SM1, SM1, S2}, xb = {S1, S2, S1, SM3};
    run("R9 ieee mag min", xa, xb, 0, 0, 4'd8, 0, {S1, SM1, SM1, S2}, 0);
    run("R9 ieee mag max", xa, xb, 0, 1, 4'd8, 0, {SM3, S2, S1, SM3}, 0);
    run("R9 cpp abs min", {SM3, SM1, SN0, 32'hFF800001}, {S1, S2, SP0, S1}, 0, 0, 4'd11, 0,
        {S1, S1, SP0, SSN}, 1);
  endtask

  task automatic t_single;
    run("R12 single32", {SSN, SSN, SSN, S1}, {S1, S1, S1, S2}, 0, 0, 4'd1, 1,
        {96'h0, S1}, 0);
    run("R12 single64", {DSN, D2}, {D1, D1}, 1, 1, 4'd1, 1, {64'h0, D2}, 0);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_ordinary();
    t_java();
    t_fortran();
    t_cstyle();
    t_zeros();
    t_ieee_nan();
    t_abs();
    t_single();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule